// File: doc/BRIEF.md
# Time-Slot Serial Transmitter with Ping-Pong Buffer

This block sends bytes supplied by a host as a serial bit stream inside one programmable window (the time-slot) of a framed serial bus. A frame starts with a frame-sync pulse. The time-slot is set by two inputs: the first bit position and the number of bits. Inside the slot the block drives data or, when it has nothing to send, logic-1 idle bits. Outside the slot the output enable is low, so an external tri-state pad leaves the line at high impedance.

The transmit store is split into two pools of 32 bytes each. The host fills one pool while the other feeds the shift register. The host writes bytes to the free pool and then issues a transmit command that carries the byte count. This hands the pool over to the shifter. A ready flag tells the host when a pool is free. A second flag reports that the last bit has left the line and that both pools are empty. An interrupt pulses when either flag rises.

The whole block runs on one system clock. The serial bit rate is given as a one-cycle bit-tick enable, and frame sync is sampled on ticks only.

Top module: `tslot_tx`

## Requirements
- R1: After `rst_n` is released: `txd`=1, `txd_oe`=0, `pool_ready`=1, `all_sent`=0 and `irq`=0.
- R2: Bit position 0 is the tick on which `fsync` is high, and each later tick adds one. On the clock edge of a tick, `txd_oe` becomes 1 exactly when that position is at or after `slot_start` and before `slot_start+slot_len`.
- R3: Whenever `txd_oe` is 0, `txd` is 1.
- R4: When no block is being sent, every in-slot bit is a logic 1 (idle fill).
- R5: Bytes are sent MSB first, one bit per in-slot tick. A block may begin only on the first bit of a slot. A command that arrives in the middle of a slot leaves the rest of that slot idle.
- R6: `pool_ready` is 1 while the pool being filled is empty. While it is 0, writes and transmit commands are ignored.
- R7: A transmit command carries a count in `xmit_cnt`. Only that many bytes are sent. A count of 0 makes the command ignored, and counts above 32 are treated as 32. Writes beyond 32 bytes in one pool are dropped.
- R8: If the second pool is already full when the first one drains, its first bit follows on the very next in-slot tick, with no idle bit in between.
- R9: On the tick after the last data bit was driven, `all_sent` becomes 1 if both pools are empty. An accepted transmit command clears it.
- R10: `irq` is high for one clock, one clock after `pool_ready` or `all_sent` goes from 0 to 1.
- R11: A `tx_reset` pulse empties both pools, stops the block in progress and clears `all_sent`. After it, in-slot bits are idle ones and `pool_ready`=1.
- R12: A block longer than the slot continues in the same slot of the following frames. When the slot length is a multiple of 8, byte boundaries line up with slot boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| fsync | input | 1 | Frame start, sampled with bit_tick |
| slot_start | input | 10 | First bit position of the time-slot |
| slot_len | input | 10 | Time-slot length in bits |
| tx_reset | input | 1 | Synchronous transmitter reset pulse |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| xmit_cmd | input | 1 | Transmit command strobe |
| xmit_cnt | input | 6 | Byte count of the committed block |
| txd | output | 1 | Serial data |
| txd_oe | output | 1 | Output enable for the tri-state pad |
| pool_ready | output | 1 | Host may load one more block |
| all_sent | output | 1 | Last bit gone and buffer empty |
| irq | output | 1 | One-clock pulse on a status rise |

## Verification
`txd` and `txd_oe` are registered, so each one reflects a tick one clock after the edge that sampled it. The bench raises `bit_tick` for one clock and reads the line at the falling edge that follows. `all_sent` is due on the tick after the last data bit, so it is compared position by position within the frame capture. `irq` is due one clock later still, so each tick gets a second falling-edge sample taken only for the interrupt. Host writes and commands are placed between ticks, so the bit position at which each block may start is known exactly.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  parameter int unsigned POOL_BYTES = 32;
  parameter int unsigned POS_W      = 10;
  localparam int unsigned IDX_W     = $clog2(POOL_BYTES);
  localparam int unsigned CNT_W     = IDX_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  // position of the bit that starts on this tick
  function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] pos,
                                                input logic sync);
    if (sync) return '0;
    if (pos == POS_MAX) return pos;
    return pos + 1'b1;
  endfunction

  // window test done one bit wider so start+len never wraps
  function automatic logic slot_hit(input logic [POS_W-1:0] pos,
                                    input logic [POS_W-1:0] start,
                                    input logic [POS_W-1:0] len);
    logic [POS_W:0] p, s, e;
    p = {1'b0, pos};
    s = {1'b0, start};
    e = s + {1'b0, len};
    return (p >= s) && (p < e);
  endfunction

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] cnt);
    if (cnt > CNT_W'(POOL_BYTES)) return CNT_W'(POOL_BYTES);
    return cnt;
  endfunction
endpackage

// File: rtl/tslot_timer.sv
module tslot_timer
  import tslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fsync,
  input  logic [POS_W-1:0] slot_start,
  input  logic [POS_W-1:0] slot_len,
  output logic             in_slot,
  output logic             slot_first
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_n;

  always_comb begin
    pos_n      = next_pos(pos_q, fsync);
    in_slot    = slot_hit(pos_n, slot_start, slot_len);
    slot_first = in_slot && (pos_n == slot_start);
  end

  // saturated value keeps the line out of the slot until the first sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= POS_MAX;
    else if (bit_tick) pos_q <= pos_n;
  end
endmodule

// File: rtl/tslot_pools.sv
module tslot_pools
  import tslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             xmit_cmd,
  input  logic [CNT_W-1:0] xmit_cnt,
  input  logic             rd_sel,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             done,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] rd_len,
  output logic [1:0]       full_vec,
  output logic             pool_ready,
  output logic             cmd_accept
);
  logic [7:0]       mem [2][POOL_BYTES];
  logic             wsel;
  logic [CNT_W-1:0] wptr;
  logic             wr_ok;
  logic [CNT_W-1:0] len_w [2];

  assign pool_ready = !full_vec[wsel];
  assign cmd_accept = xmit_cmd && pool_ready && (xmit_cnt != '0) && !clr;
  assign wr_ok      = wr_en && pool_ready && (wptr < CNT_W'(POOL_BYTES)) && !clr;
  assign rd_byte    = mem[rd_sel][rd_idx];
  assign rd_len     = len_w[rd_sel];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wsel][wptr[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      wptr <= '0;
    end else if (clr) begin
      wsel <= 1'b0;
      wptr <= '0;
    end else if (cmd_accept) begin
      wsel <= ~wsel;
      wptr <= '0;
    end else if (wr_ok) begin
      wptr <= wptr + 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pool
    logic             f_q;
    logic [CNT_W-1:0] l_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        l_q <= '0;
      end else if (clr) begin
        f_q <= 1'b0;
      end else begin
        if (done && (rd_sel == 1'(g))) f_q <= 1'b0;
        if (cmd_accept && (wsel == 1'(g))) begin
          f_q <= 1'b1;
          l_q <= clamp_len(xmit_cnt);
        end
      end
    end
    assign full_vec[g] = f_q;
    assign len_w[g]    = l_q;
  end
endmodule

// File: rtl/tslot_shifter.sv
module tslot_shifter
  import tslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_tick,
  input  logic             in_slot,
  input  logic             slot_first,
  input  logic [1:0]       full_vec,
  input  logic [7:0]       rd_byte,
  input  logic [CNT_W-1:0] rd_len,
  input  logic             cmd_accept,
  output logic             rd_sel,
  output logic [IDX_W-1:0] rd_idx,
  output logic             done,
  output logic             shift_fire,
  output logic             txd,
  output logic             txd_oe,
  output logic             all_sent
);
  logic       active;
  logic       pend;
  logic [2:0] bidx;
  logic       last_bit;
  logic       other_full;

  always_comb begin
    shift_fire = bit_tick && in_slot && full_vec[rd_sel] && (active || slot_first);
    last_bit   = (bidx == 3'd0) && ({1'b0, rd_idx} + 1'b1 == rd_len);
    done       = shift_fire && last_bit;
    other_full = full_vec[~rd_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd      <= 1'b1;
      txd_oe   <= 1'b0;
      active   <= 1'b0;
      pend     <= 1'b0;
      rd_sel   <= 1'b0;
      rd_idx   <= '0;
      bidx     <= 3'd7;
      all_sent <= 1'b0;
    end else begin
      if (bit_tick) begin
        txd_oe <= in_slot;
        txd    <= shift_fire ? rd_byte[bidx] : 1'b1;
      end
      if (clr) begin
        txd      <= 1'b1;
        active   <= 1'b0;
        pend     <= 1'b0;
        rd_sel   <= 1'b0;
        rd_idx   <= '0;
        bidx     <= 3'd7;
        all_sent <= 1'b0;
      end else begin
        // one full bit period after the final data bit
        if (bit_tick && pend) begin
          all_sent <= (full_vec == 2'b00);
          pend     <= 1'b0;
        end
        if (shift_fire) begin
          active <= 1'b1;
          if (bidx == 3'd0) begin
            bidx <= 3'd7;
            if (last_bit) begin
              rd_idx <= '0;
              rd_sel <= ~rd_sel;
              active <= other_full;
              pend   <= !other_full;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end else begin
            bidx <= bidx - 3'd1;
          end
        end
        if (cmd_accept) all_sent <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tslot_tx.sv
module tslot_tx
  import tslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fsync,
  input  logic [POS_W-1:0] slot_start,
  input  logic [POS_W-1:0] slot_len,
  input  logic             tx_reset,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             xmit_cmd,
  input  logic [CNT_W-1:0] xmit_cnt,
  output logic             txd,
  output logic             txd_oe,
  output logic             pool_ready,
  output logic             all_sent,
  output logic             irq
);
  logic             in_slot;
  logic             slot_first;
  logic             shift_fire;
  logic             done;
  logic             cmd_accept;
  logic             rd_sel;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic [CNT_W-1:0] rd_len;
  logic [1:0]       full_vec;
  logic             ready_q;
  logic             sent_q;

  tslot_timer u_timer (
    .clk, .rst_n, .bit_tick, .fsync, .slot_start, .slot_len,
    .in_slot, .slot_first
  );

  tslot_pools u_pools (
    .clk, .rst_n, .clr(tx_reset), .wr_en, .wr_data, .xmit_cmd, .xmit_cnt,
    .rd_sel, .rd_idx, .done, .rd_byte, .rd_len, .full_vec, .pool_ready,
    .cmd_accept
  );

  tslot_shifter u_shift (
    .clk, .rst_n, .clr(tx_reset), .bit_tick, .in_slot, .slot_first,
    .full_vec, .rd_byte, .rd_len, .cmd_accept, .rd_sel, .rd_idx, .done,
    .shift_fire, .txd, .txd_oe, .all_sent
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      sent_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ready_q <= pool_ready;
      sent_q  <= all_sent;
      irq     <= (pool_ready && !ready_q) || (all_sent && !sent_q);
    end
  end
endmodule

// File: rtl/tslot_tx_chk.sv
module tslot_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       in_slot,
  input logic       shift_fire,
  input logic       tx_reset,
  input logic [1:0] full_vec,
  input logic       txd,
  input logic       txd_oe,
  input logic       pool_ready,
  input logic       all_sent,
  input logic       irq
);
  p_oe_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd_oe));

  p_oe_off_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && !in_slot |=> !txd_oe);

  p_recessive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> txd);

  p_idle_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && in_slot && !shift_fire |=> txd && txd_oe);

  p_sent_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_sent |-> (full_vec == 2'b00));

  p_irq_on_sent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_sent) |=> irq);

  p_irq_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> pool_ready && !all_sent && (full_vec == 2'b00));
endmodule

bind tslot_tx tslot_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_slot(in_slot),
  .shift_fire(shift_fire), .tx_reset(tx_reset), .full_vec(full_vec),
  .txd(txd), .txd_oe(txd_oe), .pool_ready(pool_ready),
  .all_sent(all_sent), .irq(irq)
);

// File: tb/tslot_tx_test.sv
module tslot_tx_test;
  localparam int FR = 24;
  localparam int SS = 4;
  localparam int SL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       fsync = 1'b0;
  logic [9:0] slot_start = 10'(SS);
  logic [9:0] slot_len = 10'(SL);
  logic       tx_reset = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       xmit_cmd = 1'b0;
  logic [5:0] xmit_cnt = 6'd0;
  logic       txd, txd_oe, pool_ready, all_sent, irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic oe_a [FR];
  logic txd_a [FR];
  logic as_a [FR];
  logic irq_a [FR];
  logic [15:0] slot_word;
  int inj_pos = -1;
  logic [7:0] inj_byte = 8'h00;
  logic [5:0] inj_cnt = 6'd0;

  tslot_tx uut (
    .clk, .rst_n, .bit_tick, .fsync, .slot_start, .slot_len, .tx_reset,
    .wr_en, .wr_data, .xmit_cmd, .xmit_cnt, .txd, .txd_oe, .pool_ready,
    .all_sent, .irq
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [5:0] n);
    @(negedge clk); xmit_cmd = 1'b1; xmit_cnt = n;
    @(negedge clk); xmit_cmd = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); tx_reset = 1'b1;
    @(negedge clk); tx_reset = 1'b0;
  endtask

  // one frame of ticks; captures line, flags and irq per position
  task automatic run_frame();
    int bad_oe = 0;
    int bad_rec = 0;
    for (int p = 0; p < FR; p++) begin
      if (p == inj_pos) begin
        wr_byte(inj_byte);
        cmd(inj_cnt);
      end
      @(negedge clk); bit_tick = 1'b1; fsync = (p == 0);
      @(negedge clk); bit_tick = 1'b0; fsync = 1'b0;
      oe_a[p] = txd_oe; txd_a[p] = txd; as_a[p] = all_sent;
      @(negedge clk); irq_a[p] = irq;
      @(negedge clk);
    end
    inj_pos = -1;
    for (int p = 0; p < FR; p++) begin
      if (oe_a[p] !== ((p >= SS) && (p < SS + SL))) bad_oe++;
      if (!oe_a[p] && txd_a[p] !== 1'b1) bad_rec++;
    end
    check("R2", "oe window errors", bad_oe, 0);
    check("R3", "recessive errors", bad_rec, 0);
    slot_word = '0;
    for (int k = 0; k < SL; k++) slot_word = {slot_word[14:0], txd_a[SS + k]};
  endtask

  task automatic t_reset_state();
    check("R1", "txd", txd, 1);
    check("R1", "txd_oe", txd_oe, 0);
    check("R1", "pool_ready", pool_ready, 1);
    check("R1", "all_sent", all_sent, 0);
    check("R1", "irq", irq, 0);
  endtask

  task automatic t_idle();
    flush();
    run_frame();
    check("R4", "idle slot", slot_word, 16'hFFFF);
  endtask

  task automatic t_span();
    flush();
    wr_byte(8'hA5); wr_byte(8'h3C); wr_byte(8'hF0);
    cmd(6'd3);
    check("R6", "ready after one commit", pool_ready, 1);
    run_frame();
    check("R12", "first slot", slot_word, 16'hA53C);
    check("R9", "not yet sent", as_a[FR-1], 0);
    run_frame();
    check("R12", "second slot", slot_word, 16'hF0FF);
    check("R9", "sent flag on last bit", as_a[SS+7], 0);
    check("R9", "sent flag one tick later", as_a[SS+8], 1);
    check("R10", "irq after sent", irq_a[SS+8], 1);
    check("R10", "irq one clock only", irq_a[SS+9], 0);
  endtask

  task automatic t_zero_count();
    cmd(6'd0);
    @(negedge clk);
    check("R7", "zero count keeps sent", all_sent, 1);
    check("R7", "zero count keeps ready", pool_ready, 1);
    wr_byte(8'h55);
    cmd(6'd1);
    @(negedge clk);
    check("R9", "cmd clears sent", all_sent, 0);
    flush();
  endtask

  task automatic t_pingpong();
    flush();
    wr_byte(8'h81); cmd(6'd1);
    wr_byte(8'h7E); cmd(6'd1);
    @(negedge clk);
    check("R6", "ready with both pools full", pool_ready, 0);
    wr_byte(8'h00);
    cmd(6'd1);
    run_frame();
    check("R8", "back-to-back pools", slot_word, 16'h817E);
    check("R6", "ignored write and cmd", slot_word, 16'h817E);
    check("R10", "irq when pool frees", irq_a[SS+7], 1);
    check("R9", "sent after second pool", as_a[SS+16], 1);
  endtask

  task automatic t_mid_slot();
    flush();
    inj_pos = 10; inj_byte = 8'hC3; inj_cnt = 6'd1;
    run_frame();
    check("R5", "mid-slot command waits", slot_word, 16'hFFFF);
    run_frame();
    check("R5", "start at slot first bit", slot_word, 16'hC3FF);
  endtask

  task automatic t_clamp();
    int errs = 0;
    flush();
    for (int i = 0; i < 40; i++) wr_byte(8'(i + 8'h40));
    cmd(6'd40);
    for (int f = 0; f < 16; f++) begin
      run_frame();
      if (slot_word !== {8'(2*f + 8'h40), 8'(2*f + 8'h41)}) errs++;
    end
    check("R7", "clamped block frames wrong", errs, 0);
    check("R7", "sent after 32 bytes", as_a[SS+SL], 1);
    run_frame();
    check("R7", "idle after clamp", slot_word, 16'hFFFF);
  endtask

  task automatic t_txreset();
    flush();
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
    cmd(6'd4);
    run_frame();
    check("R11", "data before reset", slot_word, 16'h1122);
    flush();
    @(negedge clk);
    check("R11", "ready after reset", pool_ready, 1);
    check("R11", "sent after reset", all_sent, 0);
    run_frame();
    check("R11", "idle after reset", slot_word, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_idle();
    t_span();
    t_zero_count();
    t_pingpong();
    t_mid_slot();
    t_clamp();
    t_txreset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule